// File: doc/BRIEF.md
# Peripheral Enumeration Handshake Controller

This block runs the peripheral's half of the enumeration exchange with an infrared host. While the peripheral is unenumerated it watches decoded received-frame fields for an enumeration hail: a host frame aimed at the reserved enumeration address 0xF. When a hail arrives, the block keeps the host address it carried and asks the transmitter to send a reply whose header holds that host address, the enumeration address and a polling request. The transmitter appends the peripheral's physical ID to this reply. The block then waits for the host to echo that ID back. If the echo arrives in time, the peripheral becomes enumerated and stays that way until reset. If the echo does not arrive in time, the block draws a random back-off and lets that many hails pass before it replies again.

The block also handles a host that has gone to sleep. After a user-activity strobe, if no hail is heard for one second, the block requests a broadcast wake-up frame that has no payload. Time is counted from a one-millisecond tick input, so no clock frequency is built in.

Received frames arrive as a single-cycle `rx_valid` strobe with no ready, because an optical receiver cannot be stalled. Every `rx_valid` cycle is examined once. Transmit requests leave through a valid/ready stream. Once `tx_valid` rises, the request and all of its header fields hold steady until a cycle in which `tx_ready` is high, and the transfer completes in that cycle. `tx_valid` never falls without a transfer. The downstream side may hold `tx_ready` low for as long as it likes.

Top module: `enum_periph_ctrl`

## Requirements
- R1: After reset, `enumerated` is 0, `host_addr` is 0x00 and `tx_valid` is 0.
- R2: While unenumerated and listening, a received frame with peripheral field 0xF and control field 0x9 is a hail. A hail from any host address stores that address in `host_addr` and raises a reply request with these values: `tx_hadd` equal to the stored address, `tx_ctl` = 0x4, `tx_padd` = 0xF and `tx_with_id` = 1.
- R3: A received frame whose peripheral field is not 0xF, or whose control field is neither 0x9 nor a valid confirmation, produces no transmit request and leaves `host_addr` unchanged.
- R4: After a reply transfers, a frame with peripheral field 0xF, control field 0x8, host field equal to `host_addr` and `rx_pfid` equal to `own_pfid` sets `enumerated` to 1. This holds only if the frame arrives before the 69th millisecond tick counted from the transfer.
- R5: A confirmation whose ID differs from `own_pfid`, or whose host field differs from `host_addr`, is ignored and `enumerated` stays 0.
- R6: Once 69 ticks have passed since the reply transferred without a valid confirmation, the wait has timed out. Any confirmation after that point is ignored.
- R7: At timeout a back-off k in the range 0..7 is taken from a free-running generator that steps once per clock through all eight 3-bit values. The next k hails are ignored, and the reply goes out at hail k+1. Hails are never answered during the confirmation wait.
- R8: While listening, a `user_act` strobe starts a 1000-tick wait, and a further strobe restarts it. If the wait expires with no hail, the block requests a wake-up frame with `tx_hadd` = 0x00, `tx_ctl` = 0x4, `tx_padd` = 0xF and `tx_with_id` = 0. A hail during the wait cancels the wake-up.
- R9: While `tx_valid` is 1 and `tx_ready` is 0, the request stays valid and `tx_hadd`, `tx_ctl`, `tx_padd` and `tx_with_id` do not change.
- R10: Once `enumerated` is 1, it stays 1 until reset, no further transmit request is made, and hails are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| user_act | input | 1 | User-activity strobe |
| own_pfid | input | 32 | This peripheral's physical ID |
| rx_valid | input | 1 | A decoded received frame is present this cycle |
| rx_hadd | input | 8 | Host address field of the received frame |
| rx_ctl | input | 4 | Control nibble of the received frame |
| rx_padd | input | 4 | Peripheral address field of the received frame |
| rx_pfid | input | 32 | Physical ID carried in the received frame payload |
| tx_valid | output | 1 | Transmit request pending |
| tx_ready | input | 1 | Transmitter accepts the request this cycle |
| tx_hadd | output | 8 | Host address for the transmitted header |
| tx_ctl | output | 4 | Control nibble for the transmitted header |
| tx_padd | output | 4 | Peripheral address for the transmitted header |
| tx_with_id | output | 1 | The transmitter appends the physical ID to the payload |
| host_addr | output | 8 | Stored host address |
| enumerated | output | 1 | Enumeration complete |

## Verification
The hardest state to reach from the ports is the back-off after a timeout. The drawn value is internal, and its effect shows only as the number of hails that pass without a reply. The stimulus therefore lets the confirmation window run out repeatedly, sending a correct-but-late confirmation each time. It then sends hails one at a time and counts them until a reply is seen, which must happen by the eighth hail. The idle gap before each timeout is varied so that the generator is sampled at different phases, and the run must see more than one back-off value. The one-second wake-up path is reached in a similar way: user activity is followed by long runs of ticks, with a second activity strobe part-way through to show that the wait restarts.

// File: rtl/enum_pkg.sv
package enum_pkg;
  localparam int HADD_W = 8;
  localparam int NIB_W  = 4;

  localparam logic [NIB_W-1:0]  PADD_ENUM  = 4'hF;
  localparam logic [NIB_W-1:0]  CTL_HAIL   = 4'h9;
  localparam logic [NIB_W-1:0]  CTL_CONF   = 4'h8;
  localparam logic [NIB_W-1:0]  CTL_REQ    = 4'h4;
  localparam logic [HADD_W-1:0] HADD_BCAST = 8'h00;

  typedef enum logic [2:0] {
    ST_LISTEN,
    ST_REPLY,
    ST_CONFIRM,
    ST_BACKOFF,
    ST_WAKE,
    ST_DONE
  } enum_state_t;
endpackage

// File: rtl/enum_rx_decode.sv
module enum_rx_decode
  import enum_pkg::*;
#(
  parameter int ID_W = 32
) (
  input  logic              rx_valid,
  input  logic [HADD_W-1:0] rx_hadd,
  input  logic [NIB_W-1:0]  rx_ctl,
  input  logic [NIB_W-1:0]  rx_padd,
  input  logic [ID_W-1:0]   rx_pfid,
  input  logic [ID_W-1:0]   own_pfid,
  input  logic [HADD_W-1:0] stored_hadd,
  output logic              is_hail,
  output logic              is_confirm
);
  logic to_enum;

  always_comb begin
    to_enum    = rx_valid && (rx_padd == PADD_ENUM);
    is_hail    = to_enum && (rx_ctl == CTL_HAIL);
    is_confirm = to_enum && (rx_ctl == CTL_CONF) &&
                 (rx_hadd == stored_hadd) && (rx_pfid == own_pfid);
  end
endmodule

// File: rtl/enum_ms_timer.sv
module enum_ms_timer #(
  parameter int LIMIT = 69
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != CW'(LIMIT))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q == CW'(LIMIT));

  // R6: a cleared window cannot report expiry in the next cycle
  p_clear_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !expired);
endmodule

// File: rtl/enum_backoff_lfsr.sv
module enum_backoff_lfsr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  logic [W-1:0] s_q;
  logic         fb;
  logic         low_zero;

  assign low_zero = (s_q[W-2:0] == '0);

  generate
    if (W == 3) begin : g_w3
      assign fb = s_q[2] ^ s_q[1] ^ low_zero;
    end else if (W == 4) begin : g_w4
      assign fb = s_q[3] ^ s_q[2] ^ low_zero;
    end else begin : g_wn
      assign fb = s_q[W-1] ^ s_q[0] ^ low_zero;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= '0;
    else        s_q <= {s_q[W-2:0], fb};
  end

  assign value = s_q;
endmodule

// File: rtl/enum_periph_ctrl.sv
module enum_periph_ctrl
  import enum_pkg::*;
#(
  parameter int ID_W    = 32,
  parameter int CONF_MS = 69,
  parameter int WAKE_MS = 1000,
  parameter int BO_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              user_act,
  input  logic [ID_W-1:0]   own_pfid,
  input  logic              rx_valid,
  input  logic [HADD_W-1:0] rx_hadd,
  input  logic [NIB_W-1:0]  rx_ctl,
  input  logic [NIB_W-1:0]  rx_padd,
  input  logic [ID_W-1:0]   rx_pfid,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [HADD_W-1:0] tx_hadd,
  output logic [NIB_W-1:0]  tx_ctl,
  output logic [NIB_W-1:0]  tx_padd,
  output logic              tx_with_id,
  output logic [HADD_W-1:0] host_addr,
  output logic              enumerated
);
  enum_state_t       state_q;
  logic [HADD_W-1:0] host_q;
  logic [BO_W-1:0]   skip_q;
  logic              armed_q;
  logic              is_hail, is_confirm;
  logic              conf_exp, wake_exp;
  logic              conf_clear, wake_clear;
  logic [BO_W-1:0]   bo_draw;

  enum_rx_decode #(.ID_W(ID_W)) u_dec (
    .rx_valid    (rx_valid),
    .rx_hadd     (rx_hadd),
    .rx_ctl      (rx_ctl),
    .rx_padd     (rx_padd),
    .rx_pfid     (rx_pfid),
    .own_pfid    (own_pfid),
    .stored_hadd (host_q),
    .is_hail     (is_hail),
    .is_confirm  (is_confirm)
  );

  assign conf_clear = (state_q != ST_CONFIRM);
  assign wake_clear = user_act || !armed_q || (state_q != ST_LISTEN);

  enum_ms_timer #(.LIMIT(CONF_MS)) u_conf_tmr (
    .clk(clk), .rst_n(rst_n), .clear(conf_clear), .tick(ms_tick), .expired(conf_exp)
  );

  enum_ms_timer #(.LIMIT(WAKE_MS)) u_wake_tmr (
    .clk(clk), .rst_n(rst_n), .clear(wake_clear), .tick(ms_tick), .expired(wake_exp)
  );

  enum_backoff_lfsr #(.W(BO_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .value(bo_draw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LISTEN;
      host_q  <= '0;
      skip_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      case (state_q)
        ST_LISTEN: begin
          if (is_hail) begin
            host_q  <= rx_hadd;
            armed_q <= 1'b0;
            state_q <= ST_REPLY;
          end else if (user_act) begin
            armed_q <= 1'b1;
          end else if (armed_q && wake_exp) begin
            armed_q <= 1'b0;
            state_q <= ST_WAKE;
          end
        end
        ST_REPLY: begin
          if (tx_ready) state_q <= ST_CONFIRM;
        end
        ST_CONFIRM: begin
          if (conf_exp) begin
            skip_q  <= bo_draw;
            state_q <= ST_BACKOFF;
          end else if (is_confirm) begin
            state_q <= ST_DONE;
          end
        end
        ST_BACKOFF: begin
          if (is_hail) begin
            if (skip_q == '0) begin
              host_q  <= rx_hadd;
              state_q <= ST_REPLY;
            end else begin
              skip_q <= skip_q - 1'b1;
            end
          end
        end
        ST_WAKE: begin
          if (tx_ready) state_q <= ST_LISTEN;
        end
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_LISTEN;
      endcase
    end
  end

  always_comb begin
    tx_valid   = (state_q == ST_REPLY) || (state_q == ST_WAKE);
    tx_with_id = (state_q == ST_REPLY);
    tx_hadd    = (state_q == ST_WAKE) ? HADD_BCAST : host_q;
    tx_ctl     = CTL_REQ;
    tx_padd    = PADD_ENUM;
    host_addr  = host_q;
    enumerated = (state_q == ST_DONE);
  end

  // R9: a stalled request keeps its header
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_hadd) && $stable(tx_with_id));

  // R10: enumeration is sticky and silences the transmitter
  p_sticky_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    enumerated |=> enumerated && !tx_valid);

  // R4: enumeration only follows a decoded, matching confirmation
  p_enum_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enumerated) |-> $past(is_confirm));

  // R2: an ID-bearing reply request is always triggered by a hail
  p_reply_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) && tx_with_id |-> $past(is_hail));

  // R3: frames for other peripheral addresses leave the listener idle
  p_other_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LISTEN) && rx_valid && (rx_padd != PADD_ENUM) &&
    !(armed_q && wake_exp) |=> !tx_valid);

  // R7: the skip count never grows while backing off
  p_skip_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BACKOFF) && ($past(state_q) == ST_BACKOFF) |->
    skip_q <= $past(skip_q));
endmodule

// File: tb/enum_periph_ctrl_tb.sv
module enum_periph_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MY_ID = 32'hC0DE_1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ms_tick = 1'b0, user_act = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_hadd = '0;
  logic [3:0]  rx_ctl = '0, rx_padd = '0;
  logic [31:0] rx_pfid = '0;
  logic        tx_valid, tx_ready = 1'b1, tx_with_id, enumerated;
  logic [7:0]  tx_hadd, host_addr;
  logic [3:0]  tx_ctl, tx_padd;

  int n_cmp = 0, n_bad = 0, tx_count = 0;
  bit finished = 0;
  logic [16:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  enum_periph_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .user_act(user_act),
    .own_pfid(MY_ID), .rx_valid(rx_valid), .rx_hadd(rx_hadd), .rx_ctl(rx_ctl),
    .rx_padd(rx_padd), .rx_pfid(rx_pfid), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_hadd(tx_hadd), .tx_ctl(tx_ctl), .tx_padd(tx_padd), .tx_with_id(tx_with_id),
    .host_addr(host_addr), .enumerated(enumerated)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] pack(input logic [7:0] h, input logic wid);
    return {h, 4'h4, 4'hF, wid};
  endfunction

  // monitor: pops expected transfers as they complete
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      tx_count++;
      if (exp_q.size() == 0) chk(1'b0, "R3/R10 unexpected transfer", {15'd0, tx_hadd, tx_ctl, tx_padd, tx_with_id}, 0);
      else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        chk({tx_hadd, tx_ctl, tx_padd, tx_with_id} == e, "R2/R8 transfer header",
            {15'd0, tx_hadd, tx_ctl, tx_padd, tx_with_id}, {15'd0, e});
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic act();
    @(negedge clk) user_act = 1'b1;
    @(negedge clk) user_act = 1'b0;
  endtask

  task automatic send(input logic [7:0] h, input logic [3:0] c, input logic [3:0] p, input logic [31:0] id);
    @(negedge clk);
    rx_hadd = h; rx_ctl = c; rx_padd = p; rx_pfid = id; rx_valid = 1'b1;
    @(negedge clk) rx_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    int k;
    int distinct;
    bit seen[10];
    do_reset();
    // R1 reset state
    chk(enumerated == 1'b0, "R1 enumerated", enumerated, 0);
    chk(host_addr == 8'h00, "R1 host_addr", host_addr, 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);

    // R3: wrong peripheral address and non-hail control are ignored
    send(8'h77, 4'h9, 4'h0, 0);
    send(8'h77, 4'h8, 4'hF, MY_ID);
    send(8'h77, 4'h1, 4'hF, 0);
    cyc(3);
    chk(tx_count == 0, "R3 no transfer", tx_count, 0);
    chk(host_addr == 8'h00, "R3 host_addr untouched", host_addr, 0);

    // R2 + R9: hail under back-pressure
    @(posedge clk) #1 tx_ready = 1'b0;
    send(8'h5A, 4'h9, 4'hF, 0);
    for (int i = 0; i < 4; i++) begin
      chk(tx_valid && tx_hadd == 8'h5A && tx_with_id && tx_ctl == 4'h4 && tx_padd == 4'hF,
          "R9 held request", {15'd0, tx_hadd, tx_ctl, tx_padd, tx_with_id}, {15'd0, pack(8'h5A, 1)});
      cyc(1);
    end
    chk(host_addr == 8'h5A, "R2 host_addr captured", host_addr, 8'h5A);
    exp_q.push_back(pack(8'h5A, 1'b1));
    @(posedge clk) #1 tx_ready = 1'b1;
    cyc(2);
    chk(tx_count == 1, "R2 reply transferred", tx_count, 1);

    // R5: wrong ID and wrong host are ignored
    send(8'h5A, 4'h8, 4'hF, MY_ID ^ 32'h1);
    send(8'h5B, 4'h8, 4'hF, MY_ID);
    // R7: hail during confirmation wait is not answered
    send(8'h5A, 4'h9, 4'hF, 0);
    cyc(2);
    chk(enumerated == 1'b0, "R5 bad confirm ignored", enumerated, 0);
    chk(tx_count == 1, "R7 no reply while waiting", tx_count, 1);

    // R6 + R7: repeated timeouts and back-off counts
    for (int t = 0; t < 5; t++) begin
      cyc(t * 3 + 1);
      tick(69);
      cyc(2);
      send(8'h5A, 4'h8, 4'hF, MY_ID);
      cyc(2);
      chk(enumerated == 1'b0, "R6 late confirm ignored", enumerated, 0);
      base = tx_count;
      k = 0;
      exp_q.push_back(pack(8'h5A, 1'b1));
      while (tx_count == base && k < 9) begin
        send(8'h5A, 4'h9, 4'hF, 0);
        cyc(2);
        if (tx_count == base) k++;
      end
      chk(k <= 7 && tx_count == base + 1, "R7 back-off within 0..7", k, 7);
      seen[k] = 1'b1;
    end
    distinct = 0;
    for (int i = 0; i < 10; i++) if (seen[i]) distinct++;
    chk(distinct >= 2, "R7 back-off varies", distinct, 2);

    // R4: confirmation just inside the window
    tick(68);
    send(8'h5A, 4'h8, 4'hF, MY_ID);
    cyc(2);
    chk(enumerated == 1'b1, "R4 enumerated", enumerated, 1);
    chk(host_addr == 8'h5A, "R4 host_addr kept", host_addr, 8'h5A);

    // R10: sticky, hails ignored
    base = tx_count;
    send(8'h5A, 4'h9, 4'hF, 0);
    tick(5);
    cyc(3);
    chk(tx_count == base && enumerated == 1'b1, "R10 silent and sticky", tx_count, base);

    // R8: wake-up after one second of silence, restart on new activity
    do_reset();
    chk(enumerated == 1'b0 && host_addr == 8'h00, "R1 after second reset", {24'd0, host_addr}, 0);
    base = tx_count;
    act();
    tick(500);
    act();
    tick(999);
    cyc(4);
    chk(tx_count == base && tx_valid == 1'b0, "R8 no wake before 1000 ticks", tx_count, base);
    exp_q.push_back(pack(8'h00, 1'b0));
    tick(1);
    cyc(4);
    chk(tx_count == base + 1, "R8 wake frame sent", tx_count, base + 1);

    // R8: a hail cancels the pending wake
    base = tx_count;
    act();
    tick(500);
    exp_q.push_back(pack(8'h33, 1'b1));
    send(8'h33, 4'h9, 4'hF, 0);
    cyc(2);
    chk(host_addr == 8'h33, "R2 new host captured", host_addr, 8'h33);
    tick(600);
    cyc(4);
    chk(tx_count == base + 1, "R8 hail cancels wake", tx_count, base + 1);
    chk(exp_q.size() == 0, "R2/R8 all expected transfers seen", exp_q.size(), 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule